// File: doc/BRIEF.md
# Oversampled NRZ Bit Recovery

This block recovers data bits from a non-return-to-zero serial line. It runs on a local receive clock at a fixed multiple of the bit rate, either 8 or 16 ticks per bit, set by a parameter. It needs no recovered clock. The line first passes through a two-register synchroniser. A small state machine then keeps the last seen line level and counts ticks since the most recent bit-cell boundary.

A level change on the line marks a cell boundary. Half a bit time later, the block captures the line level and presents it on `bit_o`, together with a single-cycle strobe `bit_vld_o`. The strobe is meant to be used directly as the shift enable of a downstream shift register.

Every transition restarts the tick count, so the cell timing follows the transmitter. During runs of equal bits the block coasts: after a full bit time with no transition, it assumes a boundary and samples the next cell in the same way. A transition that lands just after such an assumed boundary is the late edge of the previous cell. It only moves the phase and never produces an extra bit.

Top module: `nrz_oversample_rx`

## Requirements
- R1: After reset, the first level change driven on `line_i` raises `bit_vld_o` exactly OSR/2+4 rising clock edges later. The path is two synchroniser registers, one boundary register, OSR/2 counted ticks and one output register.
- R2: After reset the block stays idle and gives no strobe while `line_i` keeps the level it had in reset (low), however long that lasts.
- R3: Each strobe carries the synchronised line level taken OSR/2 ticks after the latest cell boundary. For cells of exactly OSR clocks, the sequence of `bit_o` values at strobes equals the sequence of bits sent.
- R4: `bit_vld_o` is high for exactly one clock per recovered bit, never on two consecutive clocks.
- R5: Every transition restarts the cell count, wherever in the cell it falls. A strobe follows a mid-cell transition by OSR/2+4 edges, and cells one tick short (OSR-1 clocks) are recovered without loss.
- R6: When OSR ticks pass with no transition, the block assumes a boundary. While the line holds its level, strobes recur every OSR clocks and carry that level.
- R7: A transition within the first OSR/4 ticks after an assumed boundary only realigns the count and yields no extra strobe. Cells one tick long (OSR+1 clocks) are recovered one strobe per cell.
- R8: While `rst_i` is high and on the cycle after it falls, `bit_o` and `bit_vld_o` are low.
- R9: `bit_o` changes only on a cycle where `bit_vld_o` is high and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock, OSR times the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Asynchronous NRZ serial line |
| bit_o | output | 1 | Most recently recovered bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a new value on `bit_o` |

## Verification
The bench builds the block with 8 ticks per bit rather than the default 16. This keeps every cell short, so the bench can afford to count exact strobe latencies and coasting periods edge by edge. At this ratio a single tick of transmitter drift is an eighth of a cell. Cells of 7 and 9 clocks therefore put transitions just before the sample point and inside the early window after an assumed boundary, which exercises the realignment paths hardest.

// File: rtl/nrzr_pkg.sv
package nrzr_pkg;

    // Receiver mode: waiting for the first transition, or following cells
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_TRACK = 1'b1
    } rx_mode_e;

endpackage

// File: rtl/nrzr_sync.sv
module nrzr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nrzr_cell_timer.sv
module nrzr_cell_timer
    import nrzr_pkg::*;
#(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          line_i,
    output logic          bit_o,
    output logic          bit_vld_o,
    output logic          tracking_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OSR / 2);

    typedef struct packed {
        rx_mode_e      mode;
        logic          prev;
        logic [CW-1:0] cnt;
        logic          bitv;
        logic          vld;
    } timer_st_t;

    timer_st_t st_q, st_d;
    logic      level_change;

    always_comb begin
        st_d         = st_q;
        st_d.prev    = line_i;
        st_d.vld     = 1'b0;
        level_change = line_i ^ st_q.prev;

        case (st_q.mode)
            RX_IDLE: begin
                if (level_change) begin
                    st_d.mode = RX_TRACK;
                    st_d.cnt  = '0;
                end
            end
            default: begin
                // any transition is a boundary; early ones only shift phase
                if (level_change) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == LAST_TICK) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (!level_change && st_q.cnt == MID_TICK) begin
                    st_d.vld  = 1'b1;
                    st_d.bitv = line_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{mode: RX_IDLE, prev: 1'b0, cnt: '0, bitv: 1'b0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o      = st_q.bitv;
    assign bit_vld_o  = st_q.vld;
    assign tracking_o = (st_q.mode == RX_TRACK);
    assign cnt_o      = st_q.cnt;

endmodule

// File: rtl/nrz_oversample_rx.sv
module nrz_oversample_rx #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(OSR)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic bit_o,
    output logic bit_vld_o
);

    logic          line_sync;
    logic          tracking;
    logic [CW-1:0] cell_cnt;

    nrzr_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (line_i),
        .q_o   (line_sync)
    );

    nrzr_cell_timer #(
        .OSR (OSR)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .line_i     (line_sync),
        .bit_o      (bit_o),
        .bit_vld_o  (bit_vld_o),
        .tracking_o (tracking),
        .cnt_o      (cell_cnt)
    );

endmodule

// File: rtl/nrz_oversample_rx_chk.sv
module nrz_oversample_rx_chk #(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          sync_line,
    input logic          tracking,
    input logic [CW-1:0] cell_cnt,
    input logic          bit_o,
    input logic          bit_vld_o
);

    // R4
    strobe_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_o |=> !bit_vld_o);

    // R3
    strobe_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_o |-> (bit_o == $past(sync_line)));

    // R3
    strobe_mid_cell_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_o |-> ($past(cell_cnt) == CW'(OSR / 2)));

    // R5
    edge_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sync_line != $past(sync_line)) |=> (cell_cnt == '0));

    // R6
    coast_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tracking && cell_cnt == CW'(OSR - 1) && sync_line == $past(sync_line))
        |=> (cell_cnt == '0));

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tracking |=> !bit_vld_o);

    // R9
    bit_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_vld_o |-> $stable(bit_o));

endmodule

bind nrz_oversample_rx nrz_oversample_rx_chk #(.OSR(OSR)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sync_line (line_sync),
    .tracking  (tracking),
    .cell_cnt  (cell_cnt),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o)
);

// File: tb/tb_nrz_oversample_rx.sv
module tb_nrz_oversample_rx;

    localparam int OSR  = 8;
    localparam int HALF = OSR / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic bit_o;
    logic bit_vld_o;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    logic exp_q[$];
    logic prev_vld = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    nrz_oversample_rx #(.OSR(OSR)) dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .line_i    (line),
        .bit_o     (bit_o),
        .bit_vld_o (bit_vld_o)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // scoreboard monitor: compares each strobe against the expected queue
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_vld) check(!bit_vld_o, "R4 strobe width", int'(bit_vld_o), 0);
            if (bit_vld_o) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected strobe", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(bit_o == e, "R3 recovered bit", int'(bit_o), int'(e));
                end
            end
            prev_vld = bit_vld_o;
        end else begin
            prev_vld = 1'b0;
        end
    end

    task automatic do_reset();
        line = 1'b0;
        rst  = 1'b1;
        repeat (3) @(negedge clk);
        exp_q.delete();
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 4 * OSR) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // drive a level now and count rising edges until the strobe
    task automatic measure_edge(input logic lvl, input string tag);
        int n = 0;
        logic got = 1'b0;
        line = lvl;
        exp_q.push_back(lvl);
        while (!got && n < 4 * OSR) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (bit_vld_o) got = 1'b1;
        end
        check(n == HALF + 4, tag, n, HALF + 4);
    endtask

    // line held; count edges from this strobe to the next
    task automatic measure_gap(input logic lvl, input string tag);
        int n = 0;
        logic got = 1'b0;
        exp_q.push_back(lvl);
        while (!got && n < 4 * OSR) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (bit_vld_o) got = 1'b1;
        end
        check(n == OSR, tag, n, OSR);
    endtask

    // mode 0: OSR clocks, 1: OSR+1, 2: OSR-1, 3: cycling OSR-1/OSR/OSR+1
    task automatic send_seq(input logic [31:0] bits, input int nbits, input int mode);
        for (int i = 0; i < nbits; i++) begin
            int len;
            case (mode)
                0:       len = OSR;
                1:       len = OSR + 1;
                2:       len = OSR - 1;
                default: len = OSR - 1 + (i % 3);
            endcase
            line = bits[i];
            exp_q.push_back(bits[i]);
            repeat (len) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        check(!bit_vld_o, "R8 strobe in reset", int'(bit_vld_o), 0);
        check(!bit_o, "R8 bit in reset", int'(bit_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bit_vld_o && !bit_o, "R8 after release", int'({bit_o, bit_vld_o}), 0);

        // R2 idle with a quiet line
        begin
            int s0 = strobes;
            repeat (5 * OSR) @(negedge clk);
            check(strobes == s0, "R2 idle strobes", strobes - s0, 0);
        end

        // R1 first-transition latency, R5 restart on a mid-cell edge, R6 coasting
        measure_edge(1'b1, "R1 first strobe latency");
        measure_edge(1'b0, "R5 strobe after mid-cell edge");
        measure_gap(1'b0, "R6 coast period");
        measure_gap(1'b0, "R6 coast period again");
        drain("R6 drain");
        do_reset();

        // R3 nominal cells, runs up to four equal bits (R6)
        send_seq(32'h0000_C7B5, 16, 0);
        drain("R3 nominal drain");
        do_reset();

        // R7 slow transmitter: every edge lands just after an assumed boundary
        send_seq(32'h0000_0555, 12, 1);
        drain("R7 slow drain");
        do_reset();

        // R5 fast transmitter
        send_seq(32'h0000_5B6D, 16, 2);
        drain("R5 fast drain");
        do_reset();

        // R5 R7 mixed cell lengths
        send_seq(32'h0000_9A73, 16, 3);
        drain("R7 mixed drain");
        do_reset();

        // R9 output holds between strobes after reset idle
        repeat (2 * OSR) @(negedge clk);
        check(!bit_o, "R9 bit held", int'(bit_o), 0);

        done = 1'b1;
        summary();
    end

endmodule